// File: doc/BRIEF.md
# Burst Word Collector for a Serial Peripheral Link (Master Side)

This block is the master end of a four-wire serial link. It fetches one frame's worth of digital channel words from an external slave device. A single start pulse opens a burst. The block pulls the active-low slave-transmit-enable line down and toggles the serial clock for a fixed number of 16-bit words. It samples the slave's data line on every rising clock edge.

The serial clock runs only while the master has something to shift out, so every word received costs one word sent. The first outgoing word of each burst carries a single leading one, which the slave can treat as a frame-sync pulse. Every later outgoing word is all zeros.

Received words land in a small buffer. A ready flag goes high as soon as the buffer holds the whole burst. The host then reads the words out one per read strobe, oldest first. The flag drops when the last word has been read. The serial clock is derived from the system clock by a parameterised half-period divider. With the default of 12 system cycles per half period on a 250 MHz clock, the serial clock runs at about 10 MHz.

Top module: `spi_word_collector`

## Requirements
- R1: After reset, the serial clock is low, the enable line is high, the master-out line is low, and ready and busy are both low.
- R2: A start pulse while idle drives the enable line low on the next clock edge and sets busy. Enable stays low for the whole burst and returns high after the last word's final falling serial-clock edge.
- R3: While enable is high the serial clock stays low. Each burst produces exactly 14×16 = 224 rising serial-clock edges. The clock has a period of 2×HALF_CYC system clocks.
- R4: The first word shifted out in a burst is 16'h8000, sent MSB first. Its first bit is high at the first rising edge.
- R5: The other 13 words shifted out in a burst are all zeros.
- R6: The master-in line is sampled at each rising serial-clock edge. Each 16-bit received word is assembled MSB first.
- R7: The ready flag rises once the 14th word of the burst has been received, after exactly 224 rising edges.
- R8: Words are read in arrival order. The read index restarts at zero for every burst. The read data output shows the word at the current index, and each read strobe advances the index.
- R9: Ready stays high through the first 13 reads and drops after the 14th read.
- R10: A start pulse during an active burst is ignored. The burst neither restarts nor lengthens, and no extra burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a burst |
| miso_i | input | 1 | Serial data from the slave |
| rd_en_i | input | 1 | Read strobe; advances the read index |
| sclk_o | output | 1 | Serial clock, idle low |
| ste_n_o | output | 1 | Active-low slave-transmit-enable |
| mosi_o | output | 1 | Serial data to the slave |
| rd_data_o | output | 16 | Word at the current read index |
| ready_o | output | 1 | Full burst held and not yet read out |
| busy_o | output | 1 | Burst in progress |

## Verification
A wrong bit or word counter shows up directly on the serial pins. The burst ends early or late, which changes the count of rising edges seen between the enable edges. It can also misplace the sync bit or release enable too soon. Any of these is visible within the same burst, no later than the enable release. A fault in the shift register or the buffer indexing stays hidden until the readout, where a word arrives out of order or with shifted bits. A wrong fill pattern is visible at the very next rising edge where the master-out line is not low.

// File: rtl/spi_coll_pkg.sv
package spi_coll_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_t;

  // True when a counter sits on the last value of a range of the given size.
  function automatic logic at_last(input int unsigned cnt, input int unsigned size);
    return cnt == size - 1;
  endfunction

  // True for the burst slot that carries the sync marker.
  function automatic logic is_sync_slot(input int unsigned slot);
    return slot == 0;
  endfunction
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int HALF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign half_tick_o = run_i && spi_coll_pkg::at_last(int'(cnt_q), HALF_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (half_tick_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int WORD_W = 16,
  parameter int BURST  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              half_tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              ste_n_o,
  output logic              mosi_o,
  output logic              rise_ev_o,
  output logic              fall_ev_o,
  output logic              word_done_o,
  output logic              burst_end_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [$clog2(WORD_W)-1:0] bit_idx_o,
  output logic [$clog2(BURST)-1:0]  word_idx_o
);
  import spi_coll_pkg::*;
  localparam int BW = $clog2(WORD_W);
  localparam int WW = $clog2(BURST);
  localparam logic [WORD_W-1:0] SYNC_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  run_st_t           st_q;
  logic              sclk_q, ste_n_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [BW-1:0]     bit_q;
  logic [WW-1:0]     word_q;
  logic              bit_last, word_last;

  function automatic logic [WORD_W-1:0] tx_word_for(input int unsigned slot);
    return is_sync_slot(slot) ? SYNC_WORD : '0;
  endfunction

  assign bit_last    = at_last(int'(bit_q), WORD_W);
  assign word_last   = at_last(int'(word_q), BURST);
  assign busy_o      = (st_q == ST_RUN);
  assign rise_ev_o   = busy_o && half_tick_i && !sclk_q;
  assign fall_ev_o   = busy_o && half_tick_i && sclk_q;
  assign word_done_o = rise_ev_o && bit_last;
  assign burst_end_o = fall_ev_o && bit_last && word_last;
  assign rx_word_o   = {rx_q[WORD_W-2:0], miso_i};
  assign sclk_o      = sclk_q;
  assign ste_n_o     = ste_n_q;
  assign mosi_o      = tx_q[WORD_W-1];
  assign bit_idx_o   = bit_q;
  assign word_idx_o  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sclk_q  <= 1'b0;
      ste_n_q <= 1'b1;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      word_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q    <= ST_RUN;
        ste_n_q <= 1'b0;
        sclk_q  <= 1'b0;
        tx_q    <= tx_word_for(0);
        bit_q   <= '0;
        word_q  <= '0;
      end
    end else if (half_tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= rx_word_o;
      end else begin
        sclk_q <= 1'b0;
        if (bit_last) begin
          bit_q <= '0;
          if (word_last) begin
            st_q    <= ST_IDLE;
            ste_n_q <= 1'b1;
            tx_q    <= '0;
          end else begin
            word_q <= word_q + 1'b1;
            tx_q   <= tx_word_for(int'(word_q) + 1);
          end
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              ready_o
);
  import spi_coll_pkg::*;
  localparam int IW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [IW-1:0]     wr_idx_q, rd_idx_q;
  logic              ready_q;

  assign ready_o   = ready_q;
  assign rd_data_o = mem_q[rd_idx_q];

  always_ff @(posedge clk) begin
    if (wr_i) mem_q[wr_idx_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      ready_q  <= 1'b0;
    end else if (clear_i) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        wr_idx_q <= wr_idx_q + 1'b1;
        if (at_last(int'(wr_idx_q), DEPTH)) ready_q <= 1'b1;
      end
      if (rd_en_i && ready_q) begin
        if (at_last(int'(rd_idx_q), DEPTH)) begin
          rd_idx_q <= '0;
          ready_q  <= 1'b0;
        end else begin
          rd_idx_q <= rd_idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_collector.sv
module spi_word_collector #(
  parameter int WORD_W   = 16,
  parameter int BURST    = 14,
  parameter int HALF_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              miso_i,
  input  logic              rd_en_i,
  output logic              sclk_o,
  output logic              ste_n_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              ready_o,
  output logic              busy_o
);
  localparam int BW = $clog2(WORD_W);
  localparam int WW = $clog2(BURST);

  logic              half_tick, rise_ev, fall_ev, word_done, burst_end, start_ok;
  logic [WORD_W-1:0] rx_word;
  logic [BW-1:0]     bit_idx;
  logic [WW-1:0]     word_idx;

  assign start_ok = start_i && !busy_o;

  spi_sclk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(busy_o), .half_tick_o(half_tick)
  );

  spi_bit_engine #(.WORD_W(WORD_W), .BURST(BURST)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_tick_i(half_tick),
    .miso_i(miso_i), .busy_o(busy_o), .sclk_o(sclk_o), .ste_n_o(ste_n_o),
    .mosi_o(mosi_o), .rise_ev_o(rise_ev), .fall_ev_o(fall_ev),
    .word_done_o(word_done), .burst_end_o(burst_end), .rx_word_o(rx_word),
    .bit_idx_o(bit_idx), .word_idx_o(word_idx)
  );

  spi_rx_store #(.WORD_W(WORD_W), .DEPTH(BURST)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(start_ok), .wr_i(word_done),
    .wr_data_i(rx_word), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .ready_o(ready_o)
  );
endmodule

// File: rtl/spi_word_collector_chk.sv
module spi_word_collector_chk #(
  parameter int BW = 4,
  parameter int WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          sclk_o,
  input logic          ste_n_o,
  input logic          mosi_o,
  input logic          ready_o,
  input logic          busy_o,
  input logic          half_tick,
  input logic          rise_ev,
  input logic          word_done,
  input logic          burst_end,
  input logic [BW-1:0] bit_idx,
  input logic [WW-1:0] word_idx
);
  p_ste_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ste_n_o);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ste_n_o |-> !sclk_o);

  p_sclk_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> $past(half_tick));

  p_sync_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && word_idx == '0 && bit_idx == '0) |-> mosi_o);

  p_fill_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && (word_idx != '0 || bit_idx != '0)) |-> !mosi_o);

  p_ready_after_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(word_done));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !burst_end) |=> (busy_o && !ste_n_o));
endmodule

bind spi_word_collector spi_word_collector_chk #(.BW(BW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sclk_o(sclk_o),
  .ste_n_o(ste_n_o), .mosi_o(mosi_o), .ready_o(ready_o), .busy_o(busy_o),
  .half_tick(half_tick), .rise_ev(rise_ev), .word_done(word_done),
  .burst_end(burst_end), .bit_idx(bit_idx), .word_idx(word_idx)
);

// File: tb/tb_spi_word_collector.sv
`timescale 1ns/1ps
module tb_spi_word_collector;
  localparam int HALF = 12;
  localparam int NW   = 14;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, miso_i = 1'b0, rd_en_i = 1'b0;
  logic sclk_o, ste_n_o, mosi_o, ready_o, busy_o;
  logic [15:0] rd_data_o;

  spi_word_collector #(.WORD_W(16), .BURST(NW), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .miso_i(miso_i),
    .rd_en_i(rd_en_i), .sclk_o(sclk_o), .ste_n_o(ste_n_o), .mosi_o(mosi_o),
    .rd_data_o(rd_data_o), .ready_o(ready_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0, rise_cnt = 0;
  bit finished = 1'b0;
  logic [15:0] slv_w [NW];
  logic [15:0] exp_q [$];
  realtime t_first;

  initial forever #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
  end

  // Slave model: presents miso bits, captures mosi words (R4, R5, R3 period)
  initial forever begin
    logic [15:0] mw;
    @(negedge ste_n_o);
    miso_i = slv_w[0][15];
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < 16; b++) begin
        @(posedge sclk_o);
        rise_cnt++;
        mw = {mw[14:0], mosi_o};
        if (w == 0 && b == 0) t_first = $realtime;
        if (w == 0 && b == 1)
          chk(($realtime - t_first) == real'(2 * HALF * 4), "R3 period",
              32'(int'($realtime - t_first)), 32'(2 * HALF * 4));
        if (b == 15) begin
          if (w == 0) chk(mw == 16'h8000, "R4 sync word", {16'h0, mw}, 32'h8000);
          else        chk(mw == 16'h0000, "R5 fill word", {16'h0, mw}, 32'h0);
        end
        @(negedge sclk_o);
        if (b < 15)          miso_i = slv_w[w][14-b];
        else if (w < NW - 1) miso_i = slv_w[w+1][15];
      end
    end
  end

  // Monitor: pops the scoreboard as ready words are read out (R6, R7, R8, R9)
  initial forever begin
    logic [15:0] e;
    @(posedge ready_o);
    chk(rise_cnt == NW * 16, "R7 ready after full burst", 32'(rise_cnt), 32'(NW * 16));
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      e = exp_q.pop_front();
      chk(rd_data_o == e, "R6/R8 word order", {16'h0, rd_data_o}, {16'h0, e});
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      if (i == NW - 2) chk(ready_o == 1'b1, "R9 ready held", 32'(ready_o), 1);
      if (i == NW - 1) chk(ready_o == 1'b0, "R9 ready cleared", 32'(ready_o), 0);
    end
  end

  // Driver: loads slave words, pushes expected items, opens a burst
  task automatic run_burst(input int kind, input int seed, input bit dbl_start);
    for (int i = 0; i < NW; i++) begin
      case (kind)
        0: slv_w[i] = 16'hFFFF;
        1: slv_w[i] = 16'hF0F0 ^ 16'(i);
        default: slv_w[i] = 16'(seed * 4951 + i * 3855) ^ 16'hA5C3;
      endcase
      exp_q.push_back(slv_w[i]);
    end
    rise_cnt = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(!ste_n_o && busy_o, "R2 enable low on start", {ste_n_o, busy_o}, 32'h1);
    if (dbl_start) begin
      repeat (1500) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    @(posedge ste_n_o);
    chk(rise_cnt == NW * 16, "R2/R3 edges per burst", 32'(rise_cnt), 32'(NW * 16));
    while (exp_q.size() != 0 || ready_o) @(negedge clk);
    repeat (2 * HALF * 3) @(negedge clk);
    chk(rise_cnt == NW * 16 && ste_n_o && !busy_o, "R10 no extra burst",
        32'(rise_cnt), 32'(NW * 16));
  endtask

  initial begin
    @(negedge clk);
    chk(!sclk_o && ste_n_o && !mosi_o && !ready_o && !busy_o, "R1 reset state",
        {sclk_o, ste_n_o, mosi_o, ready_o, busy_o}, 32'b01000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sclk_o && ste_n_o && !ready_o, "R1 after release",
        {sclk_o, ste_n_o, ready_o}, 32'b010);
    run_burst(2, 1, 1'b0);
    run_burst(0, 0, 1'b1);   // R10: start during an active burst
    run_burst(1, 0, 1'b0);   // R8: index restarts at zero
    run_burst(2, 7, 1'b1);
    report();
  end
endmodule